// File: doc/BRIEF.md
# PHY Configuration Register Access Port

This block lets a processor reach a bank of 64 byte-wide PHY configuration registers through one 32-bit control word. Software places an address and a write byte in the word, then sets a write or read request bit in a second store. The port holds off for a programmable latency and then carries out the access. A write commits the byte to the bank. A read captures the addressed byte into the word's read-data field. In both cases the port raises an acknowledge bit.

The exchange is a four-phase, level-sensitive handshake. Software first waits for acknowledge to be low, then raises a request and waits for acknowledge to go high. It then drops the request and waits for acknowledge to return low. The bank model stands in for the PHY. Its entries hold the input-delay settings for each speed mode (0x00 to 0x08) and the clock, high-speed MMC and strobe delay-line settings (0x0B, 0x0C, 0x0D). A separate combinational tap lets the delay logic read any entry.

Top module: `phy_cfg_port`

## Requirements
- R1: After reset the control word reads all zeros and every bank entry reads zero on the delay tap.
- R2: In the control word, the address is bits 5:0, the write byte is bits 15:8, the write request is bit 24 and the read request is bit 25. Each reads back as last stored. Bits 7:6 and 31:27 always read zero.
- R3: Acknowledge (bit 26) rises exactly ACK_LAT cycles after the store that sets a request, where ACK_LAT is at least 1. It never rises while no request is set.
- R4: Acknowledge stays high while any request bit remains set. It falls one cycle after the store that clears both request bits.
- R5: A read places the addressed bank byte in bits 23:16 no later than the cycle in which acknowledge rises. The byte holds steady while acknowledge is high and afterwards until the next read completes.
- R6: A write stores the write byte at the addressed entry in the same cycle that acknowledge rises. If write and read are requested together, only the write is carried out and bits 23:16 keep their value.
- R7: Stores from the processor into bits 23:16 and bit 26 have no effect on what those bits read.
- R8: While acknowledge is high, no new access starts. Changing the address or data while the write request stays set does not commit anything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cw_we | input | 1 | Store enable for the control word |
| cw_wdata | input | 32 | Value stored into the control word |
| cw_rdata | output | 32 | Current control word, including read data and acknowledge |
| dly_sel | input | 6 | Bank entry selected for the delay tap |
| dly_val | output | 8 | Content of the selected bank entry |

## Verification
The port is driven with single writes to every speed-mode and delay-line address, then reads of the same entries. This separates the address decode from the data path and shows whether the latency count is exact. A read held for several cycles shows whether the read byte is steady for the whole time acknowledge is high. Three further patterns check that precedence and the blocking of accesses behave as required: a write and read requested together, address and data changed while acknowledge is high, and stores that try to set the read-data and acknowledge bits. Another store sets the reserved bits to confirm that they read back as zero.

// File: rtl/phy_cfg_port.sv
module phy_cfg_port #(
  parameter int ACK_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cw_we,
  input  logic [31:0] cw_wdata,
  output logic [31:0] cw_rdata,
  input  logic [5:0]  dly_sel,
  output logic [7:0]  dly_val
);
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LAT - 1);

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wd_q, rd_q;
  logic             wr_q, rq_q, ack_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    bank [DEPTH];

  wire req  = wr_q | rq_q;
  wire fire = req & ~ack_q & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      wr_q   <= 1'b0;
      rq_q   <= 1'b0;
    end else if (cw_we) begin
      addr_q <= cw_wdata[5:0];
      wd_q   <= cw_wdata[15:8];
      wr_q   <= cw_wdata[24];
      rq_q   <= cw_wdata[25];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else if (ack_q) begin
      if (!req) ack_q <= 1'b0;
    end else if (!req) begin
      cnt_q <= '0;
    end else if (fire) begin
      ack_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (fire && !wr_q) rd_q <= bank[addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (fire && wr_q) begin
      bank[addr_q] <= wd_q;
    end
  end

  assign cw_rdata = {5'b0, ack_q, rq_q, wr_q, rd_q, wd_q, 2'b0, addr_q};
  assign dly_val  = bank[dly_sel];
endmodule

// File: rtl/phy_cfg_port_chk.sv
module phy_cfg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cw
);
  wire ack = cw[26];
  wire req = cw[24] | cw[25];

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);

  // R4
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req) |=> !ack);

  // R3
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !req) |=> !ack);

  // R5
  rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack || $stable(cw[23:16])));
endmodule

bind phy_cfg_port phy_cfg_port_chk u_chk (.clk(clk), .rst_n(rst_n), .cw(cw_rdata));

// File: tb/sim_phy_cfg_port.sv
module sim_phy_cfg_port;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_we = 1'b0;
  logic [31:0] cw_wdata = '0;
  logic [31:0] cw_rdata;
  logic [5:0]  dly_sel = '0;
  logic [7:0]  dly_val;

  phy_cfg_port #(.ACK_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .cw_we(cw_we), .cw_wdata(cw_wdata),
    .cw_rdata(cw_rdata), .dly_sel(dly_sel), .dly_val(dly_val));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [5:0] a;
    logic [7:0] v;
    bit         rd;
    int         t0;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] model [64];
  logic [7:0] last_rd = '0;
  int         cyc = 0;
  int         nchk = 0;
  int         nfail = 0;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk(logic [5:0] a, logic [7:0] d, bit w, bit r);
    return {6'b0, r, w, 8'h00, d, 2'b0, a};
  endfunction

  task automatic cpu_wr(input logic [31:0] v);
    @(negedge clk);
    cw_we = 1'b1;
    cw_wdata = v;
    @(negedge clk);
    cw_we = 1'b0;
  endtask

  task automatic wait_ack(input logic v);
    while (cw_rdata[26] !== v) @(negedge clk);
  endtask

  task automatic phy_access(input logic [5:0] a, input logic [7:0] d, input bit w,
                            input bit r, input int hold, input string tag);
    exp_t e;
    wait_ack(1'b0);
    cpu_wr(mk(a, d, 1'b0, 1'b0));
    dly_sel = a;
    cpu_wr(mk(a, d, w, r));
    e.a = a; e.v = w ? d : model[a]; e.rd = !w; e.t0 = cyc; e.tag = tag;
    exp_q.push_back(e);
    if (w) model[a] = d; else last_rd = model[a];
    wait_ack(1'b1);
    repeat (hold) @(negedge clk);
    if (r && !w) chk({tag, " R5 read byte held"}, {24'h0, cw_rdata[23:16]}, {24'h0, last_rd});
    cpu_wr(mk(a, d, 1'b0, 1'b0));
    chk("R4 ack still high on clear store", {31'h0, cw_rdata[26]}, 32'h1);
    @(negedge clk);
    chk("R4 ack low one cycle after clear", {31'h0, cw_rdata[26]}, 32'h0);
  endtask

  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cw_rdata[26] && !mon_prev) begin
        if (exp_q.size() == 0) begin
          chk("R3 acknowledge without request", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " R3 latency"}, cyc - e.t0, LAT);
          if (e.rd) chk({e.tag, " R5 read data"}, {24'h0, cw_rdata[23:16]}, {24'h0, e.v});
          else      chk({e.tag, " R6 bank write"}, {24'h0, dly_val}, {24'h0, e.v});
        end
      end
      mon_prev = cw_rdata[26];
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    logic [5:0] addrs [12] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05,
                                6'h06, 6'h07, 6'h08, 6'h0B, 6'h0C, 6'h0D};
    exp_t e;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 control word after reset", cw_rdata, 32'h0);
    dly_sel = 6'h0D; #0.1 chk("R1 bank entry 0x0D", {24'h0, dly_val}, 32'h0);
    dly_sel = 6'h3F; #0.1 chk("R1 bank entry 0x3F", {24'h0, dly_val}, 32'h0);

    for (int i = 0; i < 12; i++)
      phy_access(addrs[i], 8'h31 + 8'(i * 17), 1'b1, 1'b0, 0, "R3 write");
    for (int i = 11; i >= 0; i--)
      phy_access(addrs[i], 8'h00, 1'b0, 1'b1, (i == 5) ? 4 : 0, "R5 read");

    // R6: simultaneous write and read -> write only
    phy_access(6'h20, 8'h5A, 1'b1, 1'b1, 0, "R6 both");
    chk("R6 read data untouched", {24'h0, cw_rdata[23:16]}, {24'h0, last_rd});

    // R7: stores into read-data and acknowledge positions
    cpu_wr(32'h04FF_0000 | mk(6'h11, 8'h00, 1'b0, 1'b0));
    chk("R7 ack and read data unchanged", cw_rdata, {8'h00, last_rd, 8'h00, 2'b0, 6'h11});
    repeat (2) @(negedge clk);
    chk("R7 ack stays low", {31'h0, cw_rdata[26]}, 32'h0);

    // R2: reserved bits read zero
    cpu_wr(32'hF800_00C0 | mk(6'h15, 8'hA5, 1'b0, 1'b0));
    chk("R2 field readback", cw_rdata, {8'h00, last_rd, 8'hA5, 2'b0, 6'h15});

    // R8: no new access while acknowledge is high
    wait_ack(1'b0);
    cpu_wr(mk(6'h21, 8'h11, 1'b0, 1'b0));
    dly_sel = 6'h21;
    cpu_wr(mk(6'h21, 8'h11, 1'b1, 1'b0));
    e.a = 6'h21; e.v = 8'h11; e.rd = 1'b0; e.t0 = cyc; e.tag = "R8 first";
    exp_q.push_back(e);
    model[6'h21] = 8'h11;
    wait_ack(1'b1);
    cpu_wr(mk(6'h30, 8'h77, 1'b1, 1'b0));
    repeat (5) @(negedge clk);
    chk("R8 ack held with request set", {31'h0, cw_rdata[26]}, 32'h1);
    cpu_wr(mk(6'h30, 8'h77, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    dly_sel = 6'h30; #0.1 chk("R8 second address not written", {24'h0, dly_val}, 32'h0);
    dly_sel = 6'h21; #0.1 chk("R8 first write kept", {24'h0, dly_val}, 32'h11);

    for (int i = 0; i < 12; i++) begin
      dly_sel = addrs[i];
      #0.1 chk("R6 bank contents", {24'h0, dly_val}, {24'h0, model[addrs[i]]});
    end
    chk("R3 all expected acknowledges seen", exp_q.size(), 0);
    report();
  end
endmodule